// File: doc/BRIEF.md
# Low-Power Split-Half LFSR Test Pattern Generator

This block produces stimulus vectors for built-in self-test with far fewer input toggles on the circuit under test than a plain LFSR. An 8-bit linear feedback shift register is cut into a first half (bits 1 to 4) and a last half (bits 5 to 8). A single holding flip-flop sits between the halves. Between two successive register states the block emits three extra vectors. Every bit that would flip between those two states flips exactly once across the five-vector walk, and never more.

The walk has four phases, taken one per enabled clock in a fixed order: a first-half shift (T), a last-half injection (Ta), a last-half shift (Tb) and a first-half injection (Tc). Then T comes round again. The injector compares each flip-flop with its own next-state input. Where they match it passes the value through. Where they differ it outputs the current value of bit 8, called the random bit.

A seed is loaded by the synchronous reset. After that, only the clock and the test enable are needed to run the sequence. A wider generator can place several of these side by side.

Top module: `lpg_lowpower_tpg`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register and `pattern_o` load `seed_i`, the holding flip-flop loads seed bit 4, and `phase_o` becomes 0 (phase T). Bit k of the vector (k = 1..8) is `pattern_o[8-k]`, so bit 1 is the MSB.
- R2: An enabled edge with `phase_o`=0 (T) does three things. It shifts the first half toward higher bit numbers, with bit 1 taking bit 8 XOR bit 1. The holding flip-flop captures bit 4. The last half holds. `pattern_o` shows the raw register.
- R3: An enabled edge with `phase_o`=1 (Ta) clocks no flip-flop. `pattern_o` keeps the first half and shows the injector result for the last half. The next-state input of bit 5 is the holding flip-flop; that of bit k (k = 6..8) is bit k-1.
- R4: An enabled edge with `phase_o`=2 (Tb) shifts only the last half, with bit 5 taking the holding flip-flop. `pattern_o` shows the raw register.
- R5: An enabled edge with `phase_o`=3 (Tc) clocks no flip-flop. `pattern_o` shows the injector result for the first half, and the last half is unchanged from the Tb vector.
- R6: The random bit is the current value of bit 8. From seed 0100_1011, the first five enabled edges give 1010_1011, 1010_1111, 1010_0101, 1111_0101 and 0101_0101.
- R7: `phase_o` names the phase the next enabled edge produces, and advances 0→1→2→3→0 by one on each enabled edge.
- R8: At an edge with `test_en` low, `pattern_o`, `phase_o` and all internal state hold.
- R9: The bit toggles summed over the four steps from one T vector to the next equal the Hamming distance between those two T vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| test_en | input | 1 | Advances the generator by one phase per edge when high |
| seed_i | input | 8 | Seed vector, bit 1 at the MSB |
| pattern_o | output | 8 | Registered low-power test vector |
| phase_o | output | 3 | Phase the next enabled edge will produce (0=T, 1=Ta, 2=Tb, 3=Tc) |

## Verification
`pattern_o` and `phase_o` are both registered. Each result is due exactly one rising edge after the falling edge at which the bench raised or lowered `test_en`. The driver changes inputs at falling edges and pushes the expected vector and phase for that edge into a queue. The monitor pops and compares one nanosecond after the following rising edge, so each comparison falls on the first cycle the new value is valid. The reset values are sampled at a falling edge while reset is held. The toggle-budget check is made from the observed output stream alone, each time a T vector appears.

// File: rtl/lpg_pkg.sv
// Package: shared phase encoding for the low-power pattern generator.
// Assumes a 3-bit phase field at the top-level boundary.
package lpg_pkg;

    typedef enum logic [2:0] {
        PH_T  = 3'd0,   // first half shifts, raw output
        PH_TA = 3'd1,   // no clock, last half injected
        PH_TB = 3'd2,   // last half shifts, raw output
        PH_TC = 3'd3    // no clock, first half injected
    } lpg_phase_e;

    // Successor in the fixed four-phase walk.
    function automatic lpg_phase_e phase_succ(input lpg_phase_e ph);
        case (ph)
            PH_T:    phase_succ = PH_TA;
            PH_TA:   phase_succ = PH_TB;
            PH_TB:   phase_succ = PH_TC;
            default: phase_succ = PH_T;
        endcase
    endfunction

endpackage

// File: rtl/lpg_phase_ctrl.sv
// Phase sequencer: holds the phase the next enabled edge will produce and
// steps it through T, Ta, Tb, Tc. Assumes a synchronous active-low reset.
module lpg_phase_ctrl
    import lpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    output lpg_phase_e phase_o
);

    lpg_phase_e phase_q;

    // Advance one phase per enabled edge, start at T after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_T;
        else if (step_i)
            phase_q <= phase_succ(phase_q);
    end

    assign phase_o = phase_q;

    // R7: the walk order 0,1,2,3,0
    a_r7_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && phase_q == PH_TC) |=> (phase_q == PH_T));
    a_r7_phase_from_t: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && phase_q == PH_T) |=> (phase_q == PH_TA));
    // R8: no step, no phase change
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(phase_q));

endmodule

// File: rtl/lpg_shift_core.sv
// Split shift register: a first half, a holding flip-flop and a last half.
// The first half and the holding flip-flop shift on shift_first_i. The last
// half shifts on shift_last_i, fed by the holding flip-flop. Vector bit 1 is
// the MSB, and shifts move toward lower indices (higher bit numbers).
// Assumes the two shift enables are never high together.
module lpg_shift_core #(
    parameter int HALF_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*HALF_W-1:0]   seed_i,
    input  logic                  shift_first_i,
    input  logic                  shift_last_i,
    output logic [2*HALF_W-1:0]   state_o,
    output logic [HALF_W-1:0]     nxt_first_o,
    output logic [HALF_W-1:0]     nxt_last_o
);

    localparam int W = 2 * HALF_W;

    logic [W-1:0]      st_q;
    logic              mid_q;
    logic [HALF_W-1:0] first_w;
    logic [HALF_W-1:0] last_w;

    assign first_w = st_q[W-1:HALF_W];
    assign last_w  = st_q[HALF_W-1:0];

    // Next-state inputs of both halves: feedback into bit 1, holding bit into bit 5.
    always_comb begin
        nxt_first_o = {st_q[W-1] ^ st_q[0], first_w[HALF_W-1:1]};
        nxt_last_o  = {mid_q, last_w[HALF_W-1:1]};
    end

    // Seed load on reset, otherwise per-half gated shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= seed_i;
            mid_q <= seed_i[HALF_W];
        end else begin
            if (shift_first_i) begin
                st_q[W-1:HALF_W] <= nxt_first_o;
                mid_q            <= st_q[HALF_W];
            end
            if (shift_last_i)
                st_q[HALF_W-1:0] <= nxt_last_o;
        end
    end

    assign state_o = st_q;

    // R2: the holding bit captures the last bit of the first half
    a_r2_mid_capture: assert property (@(posedge clk) disable iff (!rst_n)
        shift_first_i |=> (mid_q == $past(st_q[HALF_W])));
    // R4: the holding bit feeds the first bit of the last half
    a_r4_mid_feed: assert property (@(posedge clk) disable iff (!rst_n)
        shift_last_i |=> (st_q[HALF_W-1] == $past(mid_q)));
    // R2: the holding bit only moves with the first half
    a_r4_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_first_i |=> $stable(mid_q));

endmodule

// File: rtl/lpg_injector.sv
// Bit-wise injector: passes a bit where a flip-flop equals its next-state
// input and substitutes the random bit where they differ. Purely combinational.
module lpg_injector #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] nxt_i,
    input  logic         rbit_i,
    output logic [W-1:0] inj_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Keep the stable bit, or substitute the random bit on a pending flip.
        assign inj_o[i] = (cur_i[i] == nxt_i[i]) ? cur_i[i] : rbit_i;
    end

endmodule

// File: rtl/lpg_lowpower_tpg.sv
// Top: low-power LFSR test pattern generator. Between successive register
// states it emits two injected vectors and one half-shifted vector. The
// output is registered, and phase_o names the phase of the next enabled edge.
// Assumes a synchronous active-low reset that loads seed_i.
module lpg_lowpower_tpg
    import lpg_pkg::*;
#(
    parameter int HALF_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                test_en,
    input  logic [2*HALF_W-1:0] seed_i,
    output logic [2*HALF_W-1:0] pattern_o,
    output logic [2:0]          phase_o
);

    localparam int W = 2 * HALF_W;

    lpg_phase_e        phase;
    logic              shift_first;
    logic              shift_last;
    logic [W-1:0]      state;
    logic [HALF_W-1:0] nxt_first;
    logic [HALF_W-1:0] nxt_last;
    logic [HALF_W-1:0] inj_first;
    logic [HALF_W-1:0] inj_last;
    logic              rbit;
    logic [W-1:0]      vec_next;
    logic [W-1:0]      pat_q;

    lpg_phase_ctrl u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (test_en),
        .phase_o (phase)
    );

    // Per-half clock enables taken from the pending phase.
    always_comb begin
        shift_first = test_en && (phase == PH_T);
        shift_last  = test_en && (phase == PH_TB);
    end

    lpg_shift_core #(.HALF_W(HALF_W)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .seed_i        (seed_i),
        .shift_first_i (shift_first),
        .shift_last_i  (shift_last),
        .state_o       (state),
        .nxt_first_o   (nxt_first),
        .nxt_last_o    (nxt_last)
    );

    assign rbit = state[0];

    lpg_injector #(.W(HALF_W)) u_inj_first (
        .cur_i  (state[W-1:HALF_W]),
        .nxt_i  (nxt_first),
        .rbit_i (rbit),
        .inj_o  (inj_first)
    );

    lpg_injector #(.W(HALF_W)) u_inj_last (
        .cur_i  (state[HALF_W-1:0]),
        .nxt_i  (nxt_last),
        .rbit_i (rbit),
        .inj_o  (inj_last)
    );

    // Select the vector the pending phase produces.
    always_comb begin
        case (phase)
            PH_T:    vec_next = {nxt_first, state[HALF_W-1:0]};
            PH_TA:   vec_next = {state[W-1:HALF_W], inj_last};
            PH_TB:   vec_next = {state[W-1:HALF_W], nxt_last};
            default: vec_next = {inj_first, state[HALF_W-1:0]};
        endcase
    end

    // Output register: the seed on reset, the phase vector on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pat_q <= seed_i;
        else if (test_en)
            pat_q <= vec_next;
    end

    assign pattern_o = pat_q;
    assign phase_o   = phase;

    // R3: Ta clocks no flip-flop
    a_r3_ta_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && phase == PH_TA) |=> $stable(state));
    // R5: Tc clocks no flip-flop and repeats the last half
    a_r5_tc_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && phase == PH_TC) |=> $stable(state));
    a_r5_tc_last_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && phase == PH_TC) |=>
            (pat_q[HALF_W-1:0] == $past(pat_q[HALF_W-1:0])));
    // R2: T holds the last half
    a_r2_last_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && phase == PH_T) |=> (state[HALF_W-1:0] == $past(state[HALF_W-1:0])));
    // R4: Tb holds the first half
    a_r4_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && phase == PH_TB) |=> (state[W-1:HALF_W] == $past(state[W-1:HALF_W])));
    // R8: disabled edges change nothing
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> ($stable(pat_q) && $stable(state)));

endmodule

// File: tb/lpg_lowpower_tpg_tb.sv
// Scoreboard bench: the driver pushes the expected vector and phase for each
// edge, and the monitor pops and compares 1 ns after that rising edge.
module lpg_lowpower_tpg_tb;

    typedef struct {
        logic [7:0] vec;
        logic [2:0] ph;
        logic       en;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_en = 1'b0;
    logic [7:0] seed_i = 8'b0100_1011;
    logic [7:0] pattern_o;
    logic [2:0] phase_o;

    int checks = 0;
    int failures = 0;
    exp_t q[$];

    // reference state, bit k of the vector held in mb[k]
    logic [1:8] mb;
    logic       mm;
    int         mph;

    // toggle-budget tracking from observed outputs
    logic [7:0] prev_out;
    logic [7:0] prev_t;
    logic       have_t;
    int         tog_sum;

    always #2 clk = ~clk;   // 250 MHz

    lpg_lowpower_tpg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (test_en),
        .seed_i    (seed_i),
        .pattern_o (pattern_o),
        .phase_o   (phase_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Reference step per requirements R2..R5; returns the produced vector.
    task automatic model_step(output logic [7:0] v);
        logic nb;
        logic nx;
        case (mph)
            0: begin   // R2
                nb = mb[8] ^ mb[1];
                mm = mb[4];
                for (int k = 4; k >= 2; k--) mb[k] = mb[k-1];
                mb[1] = nb;
                v = mb;
            end
            1: begin   // R3, random bit = bit 8 (R6)
                v = mb;
                for (int k = 5; k <= 8; k++) begin
                    nx = (k == 5) ? mm : mb[k-1];
                    if (nx != mb[k]) v[8-k] = mb[8];
                end
            end
            2: begin   // R4
                for (int k = 8; k >= 6; k--) mb[k] = mb[k-1];
                mb[5] = mm;
                v = mb;
            end
            default: begin   // R5
                v = mb;
                for (int k = 1; k <= 4; k++) begin
                    nx = (k == 1) ? (mb[8] ^ mb[1]) : mb[k-1];
                    if (nx != mb[k]) v[8-k] = mb[8];
                end
            end
        endcase
        mph = (mph + 1) % 4;
    endtask

    function automatic string phase_req(input int ph);
        case (ph)
            0: phase_req = "R2";
            1: phase_req = "R3";
            2: phase_req = "R4";
            default: phase_req = "R5";
        endcase
    endfunction

    logic [7:0] last_exp;

    task automatic drive_step(input string req_override, input logic [7:0] fixed, input logic use_fixed);
        exp_t e;
        logic [7:0] v;
        string r;
        @(negedge clk);
        test_en = 1'b1;
        r = phase_req(mph);
        model_step(v);
        if (use_fixed) begin
            v = fixed;
            r = req_override;
        end
        last_exp = v;
        e.vec = v;
        e.ph = 3'(mph);
        e.en = 1'b1;
        e.req = r;
        q.push_back(e);
    endtask

    task automatic drive_idle();
        exp_t e;
        @(negedge clk);
        test_en = 1'b0;
        e.vec = last_exp;
        e.ph = 3'(mph);
        e.en = 1'b0;
        e.req = "R8";
        q.push_back(e);
    endtask

    task automatic do_reset(input logic [7:0] s);
        @(negedge clk);
        test_en = 1'b0;
        rst_n = 1'b0;
        seed_i = s;
        repeat (2) @(negedge clk);
        check("R1 pattern", pattern_o, s);
        check("R1 phase", {5'd0, phase_o}, 8'd0);
        mb = s;
        mm = s[4];
        mph = 0;
        last_exp = s;
        rst_n = 1'b1;
    endtask

    // Monitor: pops one expected item per rising edge and compares.
    always @(posedge clk) begin
        exp_t e;
        int pp;
        int tg;
        #1;
        if (!rst_n) begin
            have_t = 1'b0;
            tog_sum = 0;
            prev_out = seed_i;
        end else if (q.size() > 0) begin
            e = q.pop_front();
            check({e.req, " vector"}, pattern_o, e.vec);
            check({e.req, " phase R7"}, {5'd0, phase_o}, {5'd0, e.ph});
            if (e.en) begin
                tg = $countones(prev_out ^ pattern_o);
                tog_sum += tg;
                pp = (int'(phase_o) + 3) % 4;
                if (pp == 0) begin
                    if (have_t)
                        check("R9 toggles", 8'(tog_sum), 8'($countones(prev_t ^ pattern_o)));
                    prev_t = pattern_o;
                    have_t = 1'b1;
                    tog_sum = 0;
                end
                prev_out = pattern_o;
            end
        end
    end

    // Watchdog
    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        have_t = 1'b0;
        tog_sum = 0;
        prev_out = 8'h00;
        prev_t = 8'h00;
        do_reset(8'b0100_1011);
        // R6: documented five-vector walk from seed 0100_1011
        drive_step("R6 T1", 8'b1010_1011, 1'b1);
        drive_step("R6 Ta", 8'b1010_1111, 1'b1);
        drive_step("R6 Tb", 8'b1010_0101, 1'b1);
        drive_step("R6 Tc", 8'b1111_0101, 1'b1);
        drive_step("R6 T2", 8'b0101_0101, 1'b1);
        // R2..R5, R7, R9: free run with R8 idle gaps in every phase
        for (int i = 0; i < 60; i++) begin
            drive_step("", 8'h00, 1'b0);
            if (i % 7 == 3) begin
                drive_idle();
                drive_idle();
            end
        end
        // second seed: R1 again, then R2..R5 and R9
        do_reset(8'b1100_0011);
        for (int i = 0; i < 40; i++) begin
            drive_step("", 8'h00, 1'b0);
            if (i % 5 == 2) drive_idle();
        end
        @(negedge clk);
        test_en = 1'b0;
        repeat (3) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule